// File: doc/BRIEF.md
# Multi-Channel Device Index Selector

This block qualifies register accesses on a control port that one die shares among up to eight converter channels and up to eight auxiliary devices, such as a clock generator or a secondary converter. Two index registers hold a plain enable mask that is not decoded. A write to any per-device address produces a write strobe for every enabled channel and every enabled auxiliary device in the same cycle, so one transaction can update any subset of them. A read routes exactly one device's data onto the shared read bus. When several devices are enabled, the lowest-numbered one wins, so the bus never contends.

The block also holds a fixed chip identifier, an optional chip grade, and the two index registers. These global registers are never gated by the enables. A build with only one converter ignores the main-channel enable bits. The register banks behind the strobes are outside this block.

Top module: `dev_index_sel`

## Requirements
- R1: After reset, both index registers read 0x0F (every main-channel enable set, every auxiliary enable clear) and rdData is 0x00.
- R2: A write (regWrEn=1) to any address other than 0x001, 0x002, 0x004 and 0x005 raises chanWrStb[i] in that same cycle for every enabled channel. Channel i (0 to 3) is enabled by bit i of register 0x005, and channel 4+i by bit i of register 0x004.
- R3: Under the same write, auxWrStb[j] rises for every enabled auxiliary device. Auxiliary j (0 to 3) is enabled by bit 4+j of 0x005, and auxiliary 4+j by bit 4+j of 0x004.
- R4: No strobe is raised in a cycle without regWrEn, or when the write targets one of the four global addresses.
- R5: A write to 0x005 or 0x004 replaces that register from the next cycle on, and reading it back returns the new value. A read in the same cycle as the write returns the old value.
- R6: Reading 0x001 returns CHIP_ID. Writes to 0x001 change nothing.
- R7: Reading 0x002 returns CHIP_GRADE when GRADE_EN=1, otherwise 0x00. Writes to 0x002 change nothing.
- R8: A read (regRdEn=1) of any other address loads rdData on the next clock edge with the data of the lowest-numbered enabled device. All channels rank before all auxiliary devices.
- R9: Such a read with no device enabled loads 0x00.
- R10: rdData keeps its value in every cycle without regRdEn.
- R11: With NUM_CH=1, channel 0 is always enabled for writes and reads, whatever the main-channel enable bits hold. Auxiliary devices still follow their enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write request from the serial front end |
| regRdEn | input | 1 | Register read request from the serial front end |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | 8 | Write data |
| chanRdData | input | NUM_CH*8 | Read data of each channel bank, channel i at bits 8i+7:8i |
| auxRdData | input | NUM_AUX*8 | Read data of each auxiliary device, device j at bits 8j+7:8j |
| chanWrStb | output | NUM_CH | Per-channel write strobe |
| auxWrStb | output | NUM_AUX | Per-auxiliary write strobe |
| rdData | output | 8 | Registered read data |

## Verification
Writes are applied under several enable masks: all channels on after reset, a sparse mix of channels and auxiliaries, auxiliaries only, and nothing enabled. Together these show whether each strobe is wired to its own enable bit and its own index register. Reads under the same masks separate lowest-index priority, the rule that channels rank before auxiliaries, and the empty-mask return of zero. Writes to the global addresses show that they stay unstrobed and leave the constants unchanged. A second instance built with one channel, driven on the same bus, shows that the main enables are bypassed and that the grade register reads zero when it is disabled.

// File: rtl/dev_index_pkg.sv
package dev_index_pkg;

  localparam int ADDR_CHIP_ID = 1;
  localparam int ADDR_GRADE   = 2;
  localparam int ADDR_IDX_HI  = 4;
  localparam int ADDR_IDX_LO  = 5;

  typedef enum logic [2:0] {
    SRC_ID,
    SRC_GRADE,
    SRC_IDX_HI,
    SRC_IDX_LO,
    SRC_DEV
  } rdSrc_t;

  typedef struct packed {
    logic   wrIdxLo;
    logic   wrIdxHi;
    logic   wrDev;
    logic   rdLoad;
    rdSrc_t rdSrc;
  } ctrlStb_t;

endpackage

// File: rtl/dev_index_ctrl.sv
module dev_index_ctrl
  import dev_index_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStb_t          stb
);

  logic hitId, hitGrade, hitHi, hitLo, isGlobal;

  assign hitId    = (regAddr == ADDR_W'(ADDR_CHIP_ID));
  assign hitGrade = (regAddr == ADDR_W'(ADDR_GRADE));
  assign hitHi    = (regAddr == ADDR_W'(ADDR_IDX_HI));
  assign hitLo    = (regAddr == ADDR_W'(ADDR_IDX_LO));
  assign isGlobal = hitId | hitGrade | hitHi | hitLo;

  always_comb begin
    stb.wrIdxLo = regWrEn & hitLo;
    stb.wrIdxHi = regWrEn & hitHi;
    stb.wrDev   = regWrEn & ~isGlobal;
    stb.rdLoad  = regRdEn;
    if (hitId)         stb.rdSrc = SRC_ID;
    else if (hitGrade) stb.rdSrc = SRC_GRADE;
    else if (hitHi)    stb.rdSrc = SRC_IDX_HI;
    else if (hitLo)    stb.rdSrc = SRC_IDX_LO;
    else               stb.rdSrc = SRC_DEV;
  end

endmodule

// File: rtl/dev_index_dp.sv
module dev_index_dp
  import dev_index_pkg::*;
#(
  parameter int          NUM_CH     = 8,
  parameter int          NUM_AUX    = 8,
  parameter logic [7:0]  CHIP_ID    = 8'h5C,
  parameter logic [7:0]  CHIP_GRADE = 8'h21,
  parameter bit          GRADE_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic [7:0]           wrData,
  input  logic [NUM_CH*8-1:0]  chanRdData,
  input  logic [NUM_AUX*8-1:0] auxRdData,
  output logic [NUM_CH-1:0]    chanWrStb,
  output logic [NUM_AUX-1:0]   auxWrStb,
  output logic [7:0]           rdData
);

  localparam int NUM_DEV = NUM_CH + NUM_AUX;

  logic [7:0]         idxLo, idxHi;
  logic [7:0]         mainMask, auxMask;
  logic [NUM_CH-1:0]  chanEn;
  logic [NUM_AUX-1:0] auxEn;
  logic [NUM_DEV-1:0] devEn;
  logic [7:0]         devData [NUM_DEV];
  logic [7:0]         devPick, rdNext, gradeVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxLo <= 8'h0F;
      idxHi <= 8'h0F;
    end else begin
      if (stb.wrIdxLo) idxLo <= wrData;
      if (stb.wrIdxHi) idxHi <= wrData;
    end
  end

  assign mainMask = {idxHi[3:0], idxLo[3:0]};
  assign auxMask  = {idxHi[7:4], idxLo[7:4]};

  generate
    if (NUM_CH == 1) begin : gSingle
      assign chanEn = 1'b1;
    end else begin : gMulti
      assign chanEn = mainMask[NUM_CH-1:0];
    end
  endgenerate

  assign auxEn = auxMask[NUM_AUX-1:0];
  assign devEn = {auxEn, chanEn};

  assign chanWrStb = {NUM_CH{stb.wrDev}} & chanEn;
  assign auxWrStb  = {NUM_AUX{stb.wrDev}} & auxEn;

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : gChData
      assign devData[g] = chanRdData[g*8 +: 8];
    end
    for (genvar g = 0; g < NUM_AUX; g++) begin : gAuxData
      assign devData[NUM_CH+g] = auxRdData[g*8 +: 8];
    end
  endgenerate

  // Scan from the top down so the lowest enabled index is written last.
  always_comb begin
    devPick = 8'h00;
    for (int i = NUM_DEV - 1; i >= 0; i--) begin
      if (devEn[i]) devPick = devData[i];
    end
  end

  assign gradeVal = GRADE_EN ? CHIP_GRADE : 8'h00;

  always_comb begin
    case (stb.rdSrc)
      SRC_ID:     rdNext = CHIP_ID;
      SRC_GRADE:  rdNext = gradeVal;
      SRC_IDX_HI: rdNext = idxHi;
      SRC_IDX_LO: rdNext = idxLo;
      default:    rdNext = devPick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= 8'h00;
    else if (stb.rdLoad) rdData <= rdNext;
  end

endmodule

// File: rtl/dev_index_sel.sv
module dev_index_sel
  import dev_index_pkg::*;
#(
  parameter int         ADDR_W     = 13,
  parameter int         NUM_CH     = 8,
  parameter int         NUM_AUX    = 8,
  parameter logic [7:0] CHIP_ID    = 8'h5C,
  parameter logic [7:0] CHIP_GRADE = 8'h21,
  parameter bit         GRADE_EN   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [7:0]           regWrData,
  input  logic [NUM_CH*8-1:0]  chanRdData,
  input  logic [NUM_AUX*8-1:0] auxRdData,
  output logic [NUM_CH-1:0]    chanWrStb,
  output logic [NUM_AUX-1:0]   auxWrStb,
  output logic [7:0]           rdData
);

  ctrlStb_t stb;

  dev_index_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .stb     (stb)
  );

  dev_index_dp #(
    .NUM_CH     (NUM_CH),
    .NUM_AUX    (NUM_AUX),
    .CHIP_ID    (CHIP_ID),
    .CHIP_GRADE (CHIP_GRADE),
    .GRADE_EN   (GRADE_EN)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (regWrData),
    .chanRdData (chanRdData),
    .auxRdData  (auxRdData),
    .chanWrStb  (chanWrStb),
    .auxWrStb   (auxWrStb),
    .rdData     (rdData)
  );

endmodule

// File: rtl/dev_index_sel_chk.sv
module dev_index_sel_chk #(
  parameter int         ADDR_W  = 13,
  parameter int         NUM_CH  = 8,
  parameter int         NUM_AUX = 8,
  parameter logic [7:0] CHIP_ID = 8'h5C
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [NUM_CH-1:0]  chanWrStb,
  input logic [NUM_AUX-1:0] auxWrStb,
  input logic [7:0]         rdData
);

  logic isGlob;
  assign isGlob = (regAddr == ADDR_W'(1)) || (regAddr == ADDR_W'(2)) ||
                  (regAddr == ADDR_W'(4)) || (regAddr == ADDR_W'(5));

  // R4
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|{chanWrStb, auxWrStb}) |-> regWrEn);

  // R4
  global_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && isGlob) |-> (chanWrStb == '0 && auxWrStb == '0));

  // R6
  chip_id_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(1)) |=> (rdData == CHIP_ID));

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(rdData));

  generate
    if (NUM_CH == 1) begin : gOne
      // R11
      single_always_on_chk: assert property (@(posedge clk) disable iff (!rstN)
        (regWrEn && !isGlob) |-> chanWrStb[0]);
    end
  endgenerate

endmodule

bind dev_index_sel dev_index_sel_chk #(
  .ADDR_W  (ADDR_W),
  .NUM_CH  (NUM_CH),
  .NUM_AUX (NUM_AUX),
  .CHIP_ID (CHIP_ID)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .chanWrStb (chanWrStb),
  .auxWrStb  (auxWrStb),
  .rdData    (rdData)
);

// File: tb/tb_dev_index_sel.sv
module tb_dev_index_sel;

  localparam int         AW = 13;
  localparam logic [7:0] ID = 8'h5C;
  localparam logic [7:0] GR = 8'h21;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN, regWrEn, regRdEn;
  logic [AW-1:0] regAddr;
  logic [7:0]    regWrData;
  logic [63:0]   chanRd, auxRd;
  logic [7:0]    oneChanRd;
  logic [7:0]    chanStb, auxStb, rdData;
  logic          oneStb;
  logic [7:0]    oneAux, oneRd;

  dev_index_sel #(.ADDR_W(AW), .NUM_CH(8), .NUM_AUX(8), .CHIP_ID(ID),
                  .CHIP_GRADE(GR), .GRADE_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .chanRdData(chanRd),
    .auxRdData(auxRd), .chanWrStb(chanStb), .auxWrStb(auxStb), .rdData(rdData));

  dev_index_sel #(.ADDR_W(AW), .NUM_CH(1), .NUM_AUX(8), .CHIP_ID(ID),
                  .CHIP_GRADE(GR), .GRADE_EN(1'b0)) dutOne (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .chanRdData(oneChanRd),
    .auxRdData(auxRd), .chanWrStb(oneStb), .auxWrStb(oneAux), .rdData(oneRd));

  int vectors = 0;
  int errs = 0;
  logic [7:0] mLo, mHi, expRd, expRdOne;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit isGlobal(input logic [AW-1:0] a);
    return (a == 1) || (a == 2) || (a == 4) || (a == 5);
  endfunction

  function automatic logic [7:0] modelRead(input logic [AW-1:0] a, input bit single);
    if (a == 1) return ID;
    if (a == 2) return single ? 8'h00 : GR;
    if (a == 4) return mHi;
    if (a == 5) return mLo;
    for (int i = 0; i < 8; i++) begin
      bit en;
      if (single) en = (i == 0);
      else        en = (i < 4) ? mLo[i] : mHi[i-4];
      if (en) return single ? oneChanRd : chanRd[i*8 +: 8];
    end
    for (int j = 0; j < 8; j++) begin
      bit en;
      en = (j < 4) ? mLo[4+j] : mHi[j];
      if (en) return auxRd[j*8 +: 8];
    end
    return 8'h00;
  endfunction

  task automatic cyc(input bit we, input bit re, input logic [AW-1:0] a,
                     input logic [7:0] d, input string tag);
    bit devWr;
    logic [7:0] expCh, expAux;
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = d;
    #1;
    devWr  = we && !isGlobal(a);
    expCh  = devWr ? {mHi[3:0], mLo[3:0]} : 8'h00;
    expAux = devWr ? {mHi[7:4], mLo[7:4]} : 8'h00;
    check(devWr ? "R2" : "R4", {24'h0, chanStb}, {24'h0, expCh});
    check(devWr ? "R3" : "R4", {24'h0, auxStb}, {24'h0, expAux});
    check("R11", {31'h0, oneStb}, {31'h0, devWr});
    check("R3", {24'h0, oneAux}, {24'h0, expAux});
    @(posedge clk);
    #1;
    if (re) begin
      expRd    = modelRead(a, 1'b0);
      expRdOne = modelRead(a, 1'b1);
    end
    if (we && a == 5) mLo = d;
    if (we && a == 4) mHi = d;
    check(tag, {24'h0, rdData}, {24'h0, expRd});
    check(tag, {24'h0, oneRd}, {24'h0, expRdOne});
  endtask

  initial begin
    #(4 * 200000);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      chanRd[i*8 +: 8] = 8'h30 + 8'(i);
      auxRd[i*8 +: 8]  = 8'hC0 + 8'(i);
    end
    oneChanRd = 8'h77;
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; regAddr = '0; regWrData = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", {24'h0, rdData}, 32'h0);
    rstN = 1'b1;
    mLo = 8'h0F; mHi = 8'h0F; expRd = 8'h00; expRdOne = 8'h00;

    cyc(0, 1, 5, 0, "R1");
    cyc(0, 1, 4, 0, "R1");
    cyc(1, 0, 'h10, 8'h11, "R2");
    cyc(0, 1, 'h10, 0, "R8");
    cyc(0, 1, 1, 0, "R6");
    cyc(1, 0, 1, 8'hFF, "R6");
    cyc(0, 1, 1, 0, "R6");
    cyc(1, 1, 2, 8'h00, "R7");
    cyc(0, 1, 2, 0, "R7");
    cyc(1, 0, 5, 8'h5A, "R5");
    cyc(1, 1, 4, 8'h93, "R5");
    cyc(0, 1, 4, 0, "R5");
    cyc(1, 0, 'h20, 8'h01, "R2");
    cyc(0, 1, 'h20, 0, "R8");
    cyc(1, 0, 5, 8'h30, "R5");
    cyc(1, 0, 4, 8'h00, "R5");
    cyc(0, 1, 'h21, 0, "R8");
    cyc(1, 0, 'h22, 8'h44, "R3");
    cyc(1, 0, 5, 8'h00, "R5");
    cyc(0, 1, 'h30, 0, "R9");
    cyc(0, 0, 'h30, 0, "R10");
    cyc(1, 0, 'h00, 8'h01, "R11");
    cyc(0, 1, 'h00, 0, "R11");

    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] a;
      if (k % 16 == 0) begin
        chanRd = {$urandom, $urandom};
        auxRd  = {$urandom, $urandom};
        oneChanRd = 8'($urandom);
      end
      a = ($urandom % 3 == 0) ? AW'($urandom) : AW'($urandom % 8);
      cyc(1'($urandom), 1'($urandom), a, 8'($urandom), "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule